// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block sits between a UART receive shifter, the receive FIFO write port and the transmit path. Every received byte is checked against two programmable pairs of flow-control characters (a resume character and a pause character in each pair). A 4-bit mode field picks which pair or pairs the receiver matches and which the transmitter inserts. A matching pause character de-asserts a transmit-enable output. A matching resume character asserts it again. The transmitter samples that output only at character boundaries, so a character already on the line always finishes.

Software can ask the block to insert a resume or a pause character into the transmit stream. The character goes out through a valid/ready handshake to the transmit shifter. A separate special-character mode, usable only when all flow control is off, watches for the second pause character. It keeps the byte and raises a sticky interrupt flag until the status register is read.

Top module: `xoff_flow_ctrl`

## Requirements
- R1: After reset `tx_enable` is 1 and `rxf_wr`, `ins_valid` and `spcl_irq` are 0.
- R2: With `fc_mode[1:0]`=00, every byte offered with `rx_valid` appears on `rxf_data` with `rxf_wr`=1 one cycle later, and `tx_enable` stays 1.
- R3: With `fc_mode[1:0]`=10, a byte equal to `xoff1` drives `tx_enable` to 0 one cycle later. A byte equal to `xon1` drives it back to 1. Neither byte is stored. All other bytes, including the pair-2 characters, are stored.
- R4: With `fc_mode[1:0]`=01, the same behaviour applies to `xon2`/`xoff2`, and the pair-1 characters are stored.
- R5: With `fc_mode[1:0]`=11, `xoff1` immediately followed by `xoff2` pauses, and `xon1` immediately followed by `xon2` resumes. The first character of the pair is stored and the completing second character is not.
- R6: In mode 11, any other byte between the two characters of a pair cancels the match. All bytes of that sequence are then stored and `tx_enable` does not change.
- R7: A pulse on `send_xon`/`send_xoff` starts an insertion chosen by `fc_mode[3:2]`: 10 sends character 1 of the pair, 01 sends character 2, and 11 sends character 1 then character 2. With 00 the request is ignored. When both requests arrive together, the pause character is sent.
- R8: While `ins_valid` is 1 and `ins_ready` is 0, `ins_valid` and `ins_byte` hold. A request that arrives during an insertion is ignored.
- R9: With `spcl_en`=1 and `fc_mode`=0000, a received byte equal to `xoff2` is stored and sets `spcl_irq` one cycle later. The flag stays set until the cycle after a `stat_rd` pulse. A new match in the same cycle as the read keeps it set.
- R10: With any non-zero `fc_mode`, `spcl_en` has no effect: `spcl_irq` stays 0.
- R11: One cycle after `fc_mode[1:0]` becomes 00, `tx_enable` is 1 whatever pause state was held before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fc_mode | input | 4 | [3:2] transmit select, [1:0] receive select |
| spcl_en | input | 1 | Special-character detect enable |
| xon1 | input | 8 | Resume character 1 (bit 0 = received LSB) |
| xoff1 | input | 8 | Pause character 1 |
| xon2 | input | 8 | Resume character 2 |
| xoff2 | input | 8 | Pause character 2, also the special character |
| rx_valid | input | 1 | Received byte strobe from the shifter |
| rx_byte | input | 8 | Received byte |
| rxf_wr | output | 1 | Receive FIFO write |
| rxf_data | output | 8 | Receive FIFO write data |
| tx_enable | output | 1 | Transmitter may start a new character |
| send_xon | input | 1 | Request to insert resume character(s) |
| send_xoff | input | 1 | Request to insert pause character(s) |
| ins_ready | input | 1 | Transmit shifter accepts inserted character |
| ins_valid | output | 1 | Inserted character available |
| ins_byte | output | 8 | Inserted character |
| stat_rd | input | 1 | Status register read strobe, clears the flag |
| spcl_irq | output | 1 | Special-character detected flag |

## Verification
A stale pair-match state shows up one received byte later. A pause or resume lands on the wrong character, and a completing character is either stored or dropped against what is expected. The FIFO-side scoreboard therefore catches it on the very next write. A stuck pause bit shows up as `tx_enable` differing one cycle after the deciding byte. A wrong insertion sequence register shows up at the next handshake as a wrong byte or a missing or extra transfer.

// File: rtl/xfc_pkg.sv
// Shared encodings for the Xon/Xoff flow controller.
// Assumes the 2-bit select fields keep their bit meaning (pair 1 = 10, pair 2 = 01).
package xfc_pkg;
    localparam logic [1:0] SEL_NONE = 2'b00;
    localparam logic [1:0] SEL_P1   = 2'b10;
    localparam logic [1:0] SEL_P2   = 2'b01;
    localparam logic [1:0] SEL_BOTH = 2'b11;

    // Progress of a two-character match in pair mode
    typedef enum logic [1:0] {
        PEND_NONE = 2'd0,
        PEND_ON   = 2'd1,
        PEND_OFF  = 2'd2
    } pend_e;
endpackage

// File: rtl/xfc_sticky.sv
// Single state bit with set and clear inputs.
// SET_WINS picks which input has priority when both are high in one cycle.
module xfc_sticky #(
    parameter bit RST_VAL  = 1'b0,
    parameter bit SET_WINS = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q_d;

    generate
        if (SET_WINS) begin : g_set_pri
            // next state with set dominant
            always_comb q_d = set_i ? 1'b1 : (clr_i ? 1'b0 : q_o);
        end else begin : g_clr_pri
            // next state with clear dominant
            always_comb q_d = clr_i ? 1'b0 : (set_i ? 1'b1 : q_o);
        end
    endgenerate

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= RST_VAL;
        else        q_o <= q_d;
    end
endmodule

// File: rtl/xfc_rx_match.sv
// Receive-side matcher: compares each incoming byte with the programmed
// characters, decides whether it is stored, and raises pause/resume/special
// events in the same cycle as the byte. Assumes rx_valid is a one-cycle strobe.
module xfc_rx_match
    import xfc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    rx_sel,
    input  logic          spcl_act,
    input  logic          rx_valid,
    input  logic [CW-1:0] rx_byte,
    input  logic [CW-1:0] on1,
    input  logic [CW-1:0] off1,
    input  logic [CW-1:0] on2,
    input  logic [CW-1:0] off2,
    output logic          wr_o,
    output logic [CW-1:0] wr_data_o,
    output logic          pause_evt,
    output logic          resume_evt,
    output logic          spcl_evt
);
    pend_e pend_q, pend_d;
    logic  drop;

    // classify the current byte against the selected comparison
    always_comb begin
        drop       = 1'b0;
        pause_evt  = 1'b0;
        resume_evt = 1'b0;
        spcl_evt   = 1'b0;
        pend_d     = PEND_NONE;
        if (rx_valid) begin
            case (rx_sel)
                SEL_P1: begin
                    if (rx_byte == off1) begin
                        pause_evt = 1'b1;
                        drop      = 1'b1;
                    end else if (rx_byte == on1) begin
                        resume_evt = 1'b1;
                        drop       = 1'b1;
                    end
                end
                SEL_P2: begin
                    if (rx_byte == off2) begin
                        pause_evt = 1'b1;
                        drop      = 1'b1;
                    end else if (rx_byte == on2) begin
                        resume_evt = 1'b1;
                        drop       = 1'b1;
                    end
                end
                SEL_BOTH: begin
                    if (pend_q == PEND_OFF && rx_byte == off2) begin
                        pause_evt = 1'b1;
                        drop      = 1'b1;
                    end else if (pend_q == PEND_ON && rx_byte == on2) begin
                        resume_evt = 1'b1;
                        drop       = 1'b1;
                    end else if (rx_byte == off1) begin
                        pend_d = PEND_OFF;
                    end else if (rx_byte == on1) begin
                        pend_d = PEND_ON;
                    end
                end
                default: begin
                    spcl_evt = spcl_act && (rx_byte == off2);
                end
            endcase
        end else if (rx_sel == SEL_BOTH) begin
            pend_d = pend_q;
        end
    end

    // pair-match progress register
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= PEND_NONE;
        else        pend_q <= pend_d;
    end

    // registered FIFO write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_o      <= 1'b0;
            wr_data_o <= '0;
        end else begin
            wr_o      <= rx_valid && !drop;
            wr_data_o <= rx_byte;
        end
    end
endmodule

// File: rtl/xfc_tx_inject.sv
// Transmit-side inserter: on a request, emits one or two flow-control
// characters over a valid/ready handshake. Assumes the transmit shifter
// gives these characters priority over FIFO data.
module xfc_tx_inject
    import xfc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    tx_sel,
    input  logic          req_on,
    input  logic          req_off,
    input  logic          ready_i,
    input  logic [CW-1:0] on1,
    input  logic [CW-1:0] off1,
    input  logic [CW-1:0] on2,
    input  logic [CW-1:0] off2,
    output logic          valid_o,
    output logic [CW-1:0] byte_o
);
    logic busy_q;
    logic kind_off_q;
    logic num2_q;
    logic more_q;

    // sequence state: which character is offered and whether one follows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            kind_off_q <= 1'b0;
            num2_q     <= 1'b0;
            more_q     <= 1'b0;
        end else if (!busy_q) begin
            if ((req_on || req_off) && tx_sel != SEL_NONE) begin
                busy_q     <= 1'b1;
                kind_off_q <= req_off;
                num2_q     <= (tx_sel == SEL_P2);
                more_q     <= (tx_sel == SEL_BOTH);
            end
        end else if (ready_i) begin
            if (more_q) begin
                more_q <= 1'b0;
                num2_q <= 1'b1;
            end else begin
                busy_q <= 1'b0;
            end
        end
    end

    // character selection from the programmed registers
    always_comb begin
        case ({kind_off_q, num2_q})
            2'b00:   byte_o = on1;
            2'b01:   byte_o = on2;
            2'b10:   byte_o = off1;
            default: byte_o = off2;
        endcase
    end

    assign valid_o = busy_q;
endmodule

// File: rtl/xoff_flow_ctrl.sv
// Top of the Xon/Xoff flow controller: joins the receive matcher, the
// pause state, the special-character flag and the transmit inserter.
// Assumes the transmitter checks tx_enable only before starting a character.
module xoff_flow_ctrl
    import xfc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    fc_mode,
    input  logic          spcl_en,
    input  logic [CW-1:0] xon1,
    input  logic [CW-1:0] xoff1,
    input  logic [CW-1:0] xon2,
    input  logic [CW-1:0] xoff2,
    input  logic          rx_valid,
    input  logic [CW-1:0] rx_byte,
    output logic          rxf_wr,
    output logic [CW-1:0] rxf_data,
    output logic          tx_enable,
    input  logic          send_xon,
    input  logic          send_xoff,
    input  logic          ins_ready,
    output logic          ins_valid,
    output logic [CW-1:0] ins_byte,
    input  logic          stat_rd,
    output logic          spcl_irq
);
    logic [1:0] rx_sel;
    logic [1:0] tx_sel;
    logic       spcl_act;
    logic       pause_evt, resume_evt, spcl_evt;
    logic       paused;

    assign rx_sel   = fc_mode[1:0];
    assign tx_sel   = fc_mode[3:2];
    assign spcl_act = spcl_en && (fc_mode == 4'b0000);

    xfc_rx_match #(.CW(CW)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_sel     (rx_sel),
        .spcl_act   (spcl_act),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .on1        (xon1),
        .off1       (xoff1),
        .on2        (xon2),
        .off2       (xoff2),
        .wr_o       (rxf_wr),
        .wr_data_o  (rxf_data),
        .pause_evt  (pause_evt),
        .resume_evt (resume_evt),
        .spcl_evt   (spcl_evt)
    );

    xfc_sticky #(.RST_VAL(1'b0), .SET_WINS(1'b0)) u_pause (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (pause_evt),
        .clr_i (resume_evt || (rx_sel == SEL_NONE)),
        .q_o   (paused)
    );

    xfc_sticky #(.RST_VAL(1'b0), .SET_WINS(1'b1)) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (spcl_evt),
        .clr_i (stat_rd),
        .q_o   (spcl_irq)
    );

    xfc_tx_inject #(.CW(CW)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_sel  (tx_sel),
        .req_on  (send_xon),
        .req_off (send_xoff),
        .ready_i (ins_ready),
        .on1     (xon1),
        .off1    (xoff1),
        .on2     (xon2),
        .off2    (xoff2),
        .valid_o (ins_valid),
        .byte_o  (ins_byte)
    );

    assign tx_enable = !paused;
endmodule

// File: rtl/xfc_chk.sv
// Property checker for xoff_flow_ctrl, attached by bind.
module xfc_chk #(
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    fc_mode,
    input logic          spcl_en,
    input logic [CW-1:0] xoff1,
    input logic          rx_valid,
    input logic [CW-1:0] rx_byte,
    input logic          rxf_wr,
    input logic [CW-1:0] rxf_data,
    input logic          tx_enable,
    input logic          ins_ready,
    input logic          ins_valid,
    input logic [CW-1:0] ins_byte,
    input logic          stat_rd,
    input logic          spcl_irq
);
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fc_mode[1:0] == 2'b00) |=> (rxf_wr && rxf_data == $past(rx_byte))); // R2

    AST_NO_SPURIOUS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |=> !rxf_wr); // R2

    AST_P1_PAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fc_mode[1:0] == 2'b10 && rx_byte == xoff1) |=> (!rxf_wr && !tx_enable)); // R3

    AST_INS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ins_ready) |=> (ins_valid && $stable(ins_byte))); // R8

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (spcl_irq && !stat_rd) |=> spcl_irq); // R9

    AST_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_mode != 4'b0000 && !spcl_irq) |=> !spcl_irq); // R10

    AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_mode[1:0] == 2'b00) |=> tx_enable); // R11

    // spcl_en is part of the checked interface but needs no property of its own
    logic unused_ok;
    assign unused_ok = spcl_en;
endmodule

bind xoff_flow_ctrl xfc_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fc_mode   (fc_mode),
    .spcl_en   (spcl_en),
    .xoff1     (xoff1),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rxf_wr    (rxf_wr),
    .rxf_data  (rxf_data),
    .tx_enable (tx_enable),
    .ins_ready (ins_ready),
    .ins_valid (ins_valid),
    .ins_byte  (ins_byte),
    .stat_rd   (stat_rd),
    .spcl_irq  (spcl_irq)
);

// File: tb/xoff_flow_ctrl_bench.sv
// Scoreboard bench: driver tasks queue expected FIFO writes and inserted
// characters; monitors pop and compare them as the design produces them.
module xoff_flow_ctrl_bench;
    localparam logic [7:0] ON1 = 8'h11, OFF1 = 8'h13, ON2 = 8'h91, OFF2 = 8'h93;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] fc_mode = 4'b0000;
    logic       spcl_en = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       send_xon = 1'b0, send_xoff = 1'b0;
    logic       ins_ready = 1'b1;
    logic       stat_rd = 1'b0;
    logic       rxf_wr, tx_enable, ins_valid, spcl_irq;
    logic [7:0] rxf_data, ins_byte;

    int   n_chk = 0;
    int   n_bad = 0;
    logic [7:0] rxq[$];
    logic [7:0] txq[$];

    always #2.5 clk = ~clk;

    xoff_flow_ctrl u_xoff_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .fc_mode(fc_mode), .spcl_en(spcl_en),
        .xon1(ON1), .xoff1(OFF1), .xon2(ON2), .xoff2(OFF2),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rxf_wr(rxf_wr), .rxf_data(rxf_data),
        .tx_enable(tx_enable), .send_xon(send_xon), .send_xoff(send_xoff),
        .ins_ready(ins_ready), .ins_valid(ins_valid), .ins_byte(ins_byte),
        .stat_rd(stat_rd), .spcl_irq(spcl_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive one received byte; store=1 queues it as an expected FIFO write
    task automatic rx(input logic [7:0] b, input bit store);
        if (store) rxq.push_back(b);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_byte = b;
        @(posedge clk); #1;
        rx_valid = 1'b0;
    endtask

    task automatic req(input bit on, input bit off);
        @(posedge clk); #1;
        send_xon = on; send_xoff = off;
        @(posedge clk); #1;
        send_xon = 1'b0; send_xoff = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // FIFO-side monitor
    always @(negedge clk) begin
        if (rst_n && rxf_wr) begin
            if (rxq.size() == 0) chk(1'b0, "R2-R6 unexpected write", rxf_data, 0);
            else begin
                logic [7:0] e;
                e = rxq.pop_front();
                chk(rxf_data == e, "R2-R6 stored byte", rxf_data, e);
            end
        end
    end

    // insertion monitor
    always @(negedge clk) begin
        if (rst_n && ins_valid && ins_ready) begin
            if (txq.size() == 0) chk(1'b0, "R7 unexpected insert", ins_byte, 0);
            else begin
                logic [7:0] e;
                e = txq.pop_front();
                chk(ins_byte == e, "R7 inserted byte", ins_byte, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_enable == 1'b1, "R1 tx_enable", tx_enable, 1);
        chk(rxf_wr == 1'b0,    "R1 rxf_wr", rxf_wr, 0);
        chk(ins_valid == 1'b0, "R1 ins_valid", ins_valid, 0);
        chk(spcl_irq == 1'b0,  "R1 spcl_irq", spcl_irq, 0);

        // R2: no receive comparison
        rx(8'h41, 1); rx(OFF1, 1); rx(OFF2, 1);
        chk(tx_enable, "R2 tx_enable", tx_enable, 1);

        // R3: pair 1 single compare
        fc_mode = 4'b0010;
        rx(8'h42, 1); rx(OFF1, 0);
        chk(!tx_enable, "R3 paused by xoff1", tx_enable, 0);
        rx(OFF2, 1);
        chk(!tx_enable, "R3 pair2 byte no effect", tx_enable, 0);
        rx(ON1, 0);
        chk(tx_enable, "R3 resumed by xon1", tx_enable, 1);

        // R4: pair 2 single compare
        fc_mode = 4'b0001;
        rx(OFF1, 1);
        chk(tx_enable, "R4 pair1 byte no effect", tx_enable, 1);
        rx(OFF2, 0);
        chk(!tx_enable, "R4 paused by xoff2", tx_enable, 0);
        rx(ON2, 0);
        chk(tx_enable, "R4 resumed by xon2", tx_enable, 1);

        // R5: sequential pair
        fc_mode = 4'b0011;
        rx(OFF2, 1);
        chk(tx_enable, "R5 lone second char", tx_enable, 1);
        rx(OFF1, 1); rx(OFF2, 0);
        chk(!tx_enable, "R5 pair pause", tx_enable, 0);
        // R6: broken sequence
        rx(ON1, 1); rx(8'h55, 1); rx(ON2, 1);
        chk(!tx_enable, "R6 broken pair ignored", tx_enable, 0);
        rx(ON1, 1); rx(ON2, 0);
        chk(tx_enable, "R5 pair resume", tx_enable, 1);

        // R11: leaving receive compare frees the transmitter
        rx(OFF1, 1); rx(OFF2, 0);
        chk(!tx_enable, "R11 paused before", tx_enable, 0);
        fc_mode = 4'b0000;
        idle(1);
        @(negedge clk);
        chk(tx_enable, "R11 freed", tx_enable, 1);

        // R7: insertions
        fc_mode = 4'b1000; txq.push_back(OFF1); req(0, 1); idle(3);
        fc_mode = 4'b0100; txq.push_back(ON2);  req(1, 0); idle(3);
        fc_mode = 4'b1000; txq.push_back(OFF1); req(1, 1); idle(3);
        fc_mode = 4'b0000; req(1, 1); idle(2);
        @(negedge clk);
        chk(!ins_valid, "R7 no insert when select 00", ins_valid, 0);

        // R8: hold under back-pressure, ignore request while busy
        fc_mode = 4'b1100; ins_ready = 1'b0;
        req(0, 1); idle(3);
        @(negedge clk);
        chk(ins_valid && ins_byte == OFF1, "R8 held first char", ins_byte, OFF1);
        req(1, 0);
        @(negedge clk);
        chk(ins_valid && ins_byte == OFF1, "R8 still held", ins_byte, OFF1);
        txq.push_back(OFF1); txq.push_back(OFF2);
        @(posedge clk); #1; ins_ready = 1'b1;
        idle(4);
        @(negedge clk);
        chk(!ins_valid, "R8 busy request dropped", ins_valid, 0);
        chk(txq.size() == 0, "R7 pair sequence sent", txq.size(), 0);

        // R9: special-character detect
        fc_mode = 4'b0000; spcl_en = 1'b1;
        rx(8'h20, 1);
        chk(!spcl_irq, "R9 other byte", spcl_irq, 0);
        rx(OFF2, 1);
        chk(spcl_irq, "R9 set", spcl_irq, 1);
        idle(3);
        chk(spcl_irq, "R9 held", spcl_irq, 1);
        @(posedge clk); #1; stat_rd = 1'b1;
        @(posedge clk); #1; stat_rd = 1'b0;
        chk(!spcl_irq, "R9 cleared by read", spcl_irq, 0);
        // set wins over the read in the same cycle
        rxq.push_back(OFF2);
        @(posedge clk); #1; rx_valid = 1'b1; rx_byte = OFF2; stat_rd = 1'b1;
        @(posedge clk); #1; rx_valid = 1'b0; stat_rd = 1'b0;
        chk(spcl_irq, "R9 set beats read", spcl_irq, 1);
        @(posedge clk); #1; stat_rd = 1'b1;
        @(posedge clk); #1; stat_rd = 1'b0;

        // R10: gated off by any flow-control mode
        fc_mode = 4'b0010;
        rx(OFF2, 1);
        idle(1);
        chk(!spcl_irq, "R10 no flag with flow control", spcl_irq, 0);

        idle(3);
        chk(rxq.size() == 0, "R2-R6 all writes seen", rxq.size(), 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule